// File: doc/BRIEF.md
# Multi-core mailbox register bank

A bank of sixteen 32-bit mailbox registers serving a cluster of four cores, four mailboxes per core. Software uses the mailboxes to send inter-processor interrupt requests (mailbox 0 of each core) and to release a waiting secondary core at boot. For the boot case, a nonzero start address is written into mailbox 3 of that core, and the core polls for it.

Each mailbox has two write addresses. Writing the set address ORs the data into the mailbox. Writing the clear address clears every bit that is one in the data. Reading the clear address returns the stored value. Each mailbox drives a level interrupt that is high while the mailbox holds any one bit. Each core also gets a combined interrupt, which is the OR of its four mailbox interrupts.

The register port is a simple single-cycle read/write port, replicated so that several masters can reach the bank in the same cycle. Read data is registered and appears in the cycle after the read request.

Top module: `mbox_bank`

## Requirements
- R1: After reset every mailbox is zero, every mailbox and core interrupt output is low, and every read data output is zero.
- R2: A write to byte offset 0x080 + 4*m + 16*c sets mailbox m of core c to its old value ORed with the write data (m and c in 0..3).
- R3: A write to byte offset 0x0C0 + 4*m + 16*c clears every bit of mailbox m of core c whose write-data bit is one and leaves the other bits unchanged.
- R4: A read of a clear-window address returns the addressed mailbox's value on rdata_o in the cycle after the request. A read of a set-window address returns zero. rdata_o is zero in any cycle that follows no read request on that port.
- R5: mbox_irq_o[4*c + m] is high exactly while mailbox m of core c is nonzero, and falls in the cycle the mailbox becomes all zeros.
- R6: core_irq_o[c] is the OR of mbox_irq_o[4*c] through mbox_irq_o[4*c + 3].
- R7: When writes from different ports reach the same mailbox in one cycle, all clear masks are applied first and all set masks second, so the result is (old & ~clear_or) | set_or.
- R8: Writes to offsets outside 0x080..0x0FF, and writes to offsets that are not multiples of four, change no mailbox. Reads from such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_PORTS | Per-port access request |
| we_i | input | N_PORTS | Per-port write enable (1 write, 0 read) |
| addr_i | input | N_PORTS x ADDR_W | Per-port byte offset |
| wdata_i | input | N_PORTS x DATA_W | Per-port write data |
| rdata_o | output | N_PORTS x DATA_W | Per-port registered read data |
| mbox_irq_o | output | N_CORES*N_MBOX | Mailbox interrupt, index 4*core + mailbox |
| core_irq_o | output | N_CORES | Combined interrupt per core |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same mailbox in the same cycle. A single master can never produce it. The bench therefore drives both ports in one cycle: one port writes the set address and the other writes the clear address of the same mailbox. The two masks overlap, so the expected value shows whether the clear-then-set order holds. Two concurrent sets and two concurrent clears on one mailbox are driven the same way. The ignored-write cases are checked by reading back every mailbox through the clear window after writes to addresses below, above and misaligned within the windows.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int N_TOTAL  = 16,
  parameter int SET_BASE = 'h080,
  parameter int CLR_BASE = 'h0C0,
  localparam int IDX_W   = $clog2(N_TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_o,
  output logic              rd_o
);
  localparam int WIN_BYTES = 4 * N_TOTAL;
  localparam logic [ADDR_W-1:0] SET_LO = ADDR_W'(SET_BASE);
  localparam logic [ADDR_W-1:0] SET_HI = ADDR_W'(SET_BASE + WIN_BYTES);
  localparam logic [ADDR_W-1:0] CLR_LO = ADDR_W'(CLR_BASE);
  localparam logic [ADDR_W-1:0] CLR_HI = ADDR_W'(CLR_BASE + WIN_BYTES);

  logic              aligned, in_set, in_clr;
  logic [ADDR_W-1:0] off;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_set  = aligned && (addr_i >= SET_LO) && (addr_i < SET_HI);
  assign in_clr  = aligned && (addr_i >= CLR_LO) && (addr_i < CLR_HI);

  always_comb begin
    win_o = WIN_NONE;
    off   = '0;
    if (in_set) begin
      win_o = WIN_SET;
      off   = addr_i - SET_LO;
    end else if (in_clr) begin
      win_o = WIN_CLR;
      off   = addr_i - CLR_LO;
    end
  end

  assign idx_o = off[IDX_W+1:2];
  assign wr_o  = req_i && we_i;
  assign rd_o  = req_i && !we_i;

  // R8: a decoded window hit always comes from an aligned offset
  p_hit_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_o != WIN_NONE) |-> (addr_i[1:0] == 2'b00));
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell
  import mbox_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_PORTS = 2,
  parameter int N_TOTAL = 16,
  parameter int IDX     = 0,
  localparam int IDX_W  = $clog2(N_TOTAL)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             wr_i,
  input  win_e [N_PORTS-1:0]             win_i,
  input  logic [N_PORTS-1:0][IDX_W-1:0]  idx_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0]              q_o,
  output logic                           irq_o
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

  logic [DATA_W-1:0] set_m, clr_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (wr_i[p] && idx_i[p] == MY_IDX) begin
        if (win_i[p] == WIN_SET) set_m |= wdata_i[p];
        if (win_i[p] == WIN_CLR) clr_m |= wdata_i[p];
      end
    end
  end

  // clear first, then set: newly set bits survive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_m) | set_m;
  end

  assign irq_o = |q_o;

  p_set_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m != '0) |=> ((q_o & $past(set_m)) == $past(set_m)));

  p_clr_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m == '0 && clr_m != '0) |=> ((q_o & $past(clr_m)) == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m == '0 && clr_m == '0) |=> $stable(q_o));

  p_irq_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (q_o & ~clr_m) == '0 && set_m == '0) |=> !irq_o);
endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
  import mbox_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_TOTAL = 16,
  localparam int IDX_W  = $clog2(N_TOTAL)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_i,
  input  win_e                           win_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [N_TOTAL-1:0][DATA_W-1:0] mbox_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [DATA_W-1:0] rd_d;

  assign rd_d = (rd_i && win_i == WIN_CLR) ? mbox_i[idx_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end

  p_rd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && win_i == WIN_CLR) |=> (rdata_o == '0));

  p_rd_val_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && win_i == WIN_CLR) |=> (rdata_o == $past(mbox_i[idx_i])));
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int N_PORTS  = 2,
  parameter int N_CORES  = 4,
  parameter int N_MBOX   = 4,
  parameter int SET_BASE = 'h080,
  parameter int CLR_BASE = 'h0C0,
  localparam int N_TOTAL = N_CORES * N_MBOX,
  localparam int IDX_W   = $clog2(N_TOTAL)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             req_i,
  input  logic [N_PORTS-1:0]             we_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] addr_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] wdata_i,
  output logic [N_PORTS-1:0][DATA_W-1:0] rdata_o,
  output logic [N_TOTAL-1:0]             mbox_irq_o,
  output logic [N_CORES-1:0]             core_irq_o
);
  win_e [N_PORTS-1:0]             win;
  logic [N_PORTS-1:0][IDX_W-1:0]  idx;
  logic [N_PORTS-1:0]             wr, rd;
  logic [N_TOTAL-1:0][DATA_W-1:0] mbox_q;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    mbox_decode #(
      .ADDR_W(ADDR_W), .N_TOTAL(N_TOTAL),
      .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
      .clk_i, .rst_ni,
      .req_i(req_i[p]), .we_i(we_i[p]), .addr_i(addr_i[p]),
      .win_o(win[p]), .idx_o(idx[p]), .wr_o(wr[p]), .rd_o(rd[p])
    );

    mbox_rdmux #(.DATA_W(DATA_W), .N_TOTAL(N_TOTAL)) u_rd (
      .clk_i, .rst_ni,
      .rd_i(rd[p]), .win_i(win[p]), .idx_i(idx[p]),
      .mbox_i(mbox_q), .rdata_o(rdata_o[p])
    );
  end

  for (genvar i = 0; i < N_TOTAL; i++) begin : g_mbox
    mbox_cell #(
      .DATA_W(DATA_W), .N_PORTS(N_PORTS), .N_TOTAL(N_TOTAL), .IDX(i)
    ) u_cell (
      .clk_i, .rst_ni,
      .wr_i(wr), .win_i(win), .idx_i(idx), .wdata_i(wdata_i),
      .q_o(mbox_q[i]), .irq_o(mbox_irq_o[i])
    );
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    assign core_irq_o[c] = |mbox_irq_o[c*N_MBOX +: N_MBOX];
  end

  // R6: a quiet core output means every mailbox of that core is empty
  for (genvar c = 0; c < N_CORES; c++) begin : g_core_chk
    p_core_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !core_irq_o[c] |-> (mbox_q[c*N_MBOX +: N_MBOX] == '0));
  end
endmodule

// File: tb/mbox_bank_tb.sv
module mbox_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int NP = 2;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NP-1:0]          req = '0;
  logic [NP-1:0]          we = '0;
  logic [NP-1:0][AW-1:0]  addr = '0;
  logic [NP-1:0][DW-1:0]  wdata = '0;
  logic [NP-1:0][DW-1:0]  rdata;
  logic [15:0]            mirq;
  logic [3:0]             cirq;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .mbox_irq_o(mirq), .core_irq_o(cirq)
  );

  function automatic logic [AW-1:0] set_a(int c, int m);
    return AW'('h080 + 4*m + 16*c);
  endfunction
  function automatic logic [AW-1:0] clr_a(int c, int m);
    return AW'('h0C0 + 4*m + 16*c);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    req = '0; we = '0; addr = '0; wdata = '0;
  endtask

  // one cycle: inputs already driven at a negedge, commit at posedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(int p, logic [AW-1:0] a, logic [DW-1:0] d);
    req[p] = 1'b1; we[p] = 1'b1; addr[p] = a; wdata[p] = d;
  endtask

  task automatic rd_req(int p, logic [AW-1:0] a);
    req[p] = 1'b1; we[p] = 1'b0; addr[p] = a;
  endtask

  task automatic read(int p, logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_req(p, a);
    step();
    d = rdata[p];
  endtask

  task automatic check_irqs(string tag);
    logic [15:0] em;
    logic [3:0]  ec;
    for (int i = 0; i < 16; i++) em[i] = (model[i] != '0);
    for (int c = 0; c < 4; c++) ec[c] = |em[4*c +: 4];
    chk({tag, " R5 mbox irq"}, DW'(mirq), DW'(em));
    chk({tag, " R6 core irq"}, DW'(cirq), DW'(ec));
  endtask

  task automatic check_all(string tag);
    logic [DW-1:0] d;
    for (int i = 0; i < 16; i++) begin
      read(i % 2, clr_a(i / 4, i % 4), d);
      chk(tag, d, model[i]);
    end
  endtask

  task automatic t_reset();
    check_irqs("R1 reset");
    chk("R1 rdata0", rdata[0], '0);
    chk("R1 rdata1", rdata[1], '0);
    check_all("R1 reset value");
  endtask

  task automatic t_set();
    wr(0, set_a(0, 3), 32'h8000_1000); model[3] |= 32'h8000_1000; step();
    check_irqs("R2 boot addr");
    chk("R4 rdata idle after write", rdata[0], '0);
    wr(1, set_a(2, 1), 32'h0000_0005); model[9] |= 32'h5; step();
    wr(0, set_a(2, 1), 32'h0000_0030); model[9] |= 32'h30; step();
    check_irqs("R2 or");
    wr(0, set_a(3, 0), 32'h1); model[12] |= 32'h1; step();
    check_all("R2 set value");
  endtask

  task automatic t_clear();
    logic [DW-1:0] d;
    wr(0, clr_a(2, 1), 32'h0000_0014); model[9] &= ~32'h14; step();
    read(1, clr_a(2, 1), d);
    chk("R3 partial clear", d, model[9]);
    check_irqs("R3 partial");
    wr(1, clr_a(2, 1), 32'hFFFF_FFFF); model[9] = '0; step();
    check_irqs("R5 drop at zero");
    chk("R5 irq9 low", DW'(mirq[9]), '0);
    read(0, set_a(0, 3), d);
    chk("R4 set window reads zero", d, '0);
    read(0, clr_a(0, 3), d);
    chk("R4 poll boot addr", d, 32'h8000_1000);
  endtask

  task automatic t_concurrent();
    wr(0, set_a(1, 1), 32'h0000_0FF0);
    model[5] |= 32'h0FF0; step();
    // overlapping clear and set on the same mailbox
    wr(0, set_a(1, 1), 32'h0000_00F0);
    wr(1, clr_a(1, 1), 32'h0000_00FF);
    model[5] = (model[5] & ~32'h00FF) | 32'h00F0; step();
    check_irqs("R7 set+clr");
    wr(0, set_a(1, 2), 32'h0101_0000);
    wr(1, set_a(1, 2), 32'h0000_0202);
    model[6] |= 32'h0101_0202; step();
    wr(0, clr_a(1, 2), 32'h0100_0000);
    wr(1, clr_a(1, 2), 32'h0000_0002);
    model[6] &= ~32'h0100_0002; step();
    check_all("R7 concurrent value");
  endtask

  task automatic t_outside();
    logic [DW-1:0] d;
    wr(0, 12'h000, 32'hFFFF_FFFF); wr(1, 12'h07C, 32'hFFFF_FFFF); step();
    wr(0, 12'h100, 32'hFFFF_FFFF); wr(1, 12'h081, 32'hFFFF_FFFF); step();
    wr(0, 12'h0C2, 32'hFFFF_FFFF); wr(1, 12'hFFC, 32'hFFFF_FFFF); step();
    check_irqs("R8 ignored");
    check_all("R8 ignored write");
    read(0, 12'h07C, d); chk("R8 read low", d, '0);
    read(1, 12'h100, d); chk("R8 read high", d, '0);
    read(0, 12'h0CD, d); chk("R8 read misaligned", d, '0);
  endtask

  task automatic t_drain();
    for (int i = 0; i < 16; i++) begin
      wr(0, clr_a(i / 4, i % 4), 32'hFFFF_FFFF);
      model[i] = '0;
      step();
    end
    check_irqs("R5 all clear");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_concurrent();
    t_outside();
    t_drain();
    summary();
  end
endmodule